// File: doc/BRIEF.md
# Masked Multi-Lane Vector ALU

This unit runs one element-wise integer operation over the leading `vl` elements of two operand vectors. Each operation is add, subtract, multiply or one of three compares. Elements are spread over `LANES` identical lanes, so element `i` goes to lane `i mod LANES` in group `i / LANES`. Every lane receives the same control, and no lane talks to another. In one form the first operand comes from the vector stream. In the other form a single scalar replaces it for every element.

The caller pulses `start` while `ready` is high. The caller also presents the operation code, the form, the mask select, the length and the scalar. The unit then raises `grp_req` for one cycle per element group and shows the group number on `grp_idx`. In each of those cycles the caller puts that group's operands on `a_grp` and `b_grp`. Results come out per lane on `res_data`, with a write strobe per lane and the group number on `res_grp`. A compare writes one bit per element into a flag register, which is visible on `flags`. A later masked arithmetic operation writes only the elements whose flag bit is 1. `done` pulses with the last result beat.

Top module: `vec_alu`

## Requirements
- R1: With the vector form (`scalar_form`=0), operation code 0 gives a[i]+b[i], code 1 gives a[i]-b[i] and code 2 gives the low W bits of a[i]*b[i]. All results wrap modulo 2^W.
- R2: With the scalar form (`scalar_form`=1), the scalar input takes the place of a[i] for every element, and `a_grp` is not used.
- R3: Element i is handled in group i/LANES and appears in the field `[l*W +: W]` of `res_data` and at bit l of `res_we`, where l = i mod LANES. The group number is shown on `res_grp` in the same cycle.
- R4: Elements at index `vl` or above get no result write and no flag change. A `vl` value above MVL (64) is treated as MVL.
- R5: An operation with `vl`=0 raises no `grp_req`, makes no write and no flag change, and pulses `done` on the second rising edge after the edge that accepted it.
- R6: Code 4 sets flag[i] to (x[i] != b[i]), code 5 sets it to (x[i] == b[i]) and code 6 sets it to (x[i] < b[i], unsigned). Here x[i] is a[i] or the scalar, depending on the form. Only flags below `vl` change.
- R7: With `masked`=1, an arithmetic operation writes element i only when flag[i] is 1.
- R8: With `masked`=0, an arithmetic operation writes every element below `vl`, whatever the flag register holds.
- R9: An accepted operation raises `grp_req` for ceil(vl/LANES) consecutive cycles, with `grp_idx` counting up from 0. Group g's operands are sampled at the end of its request cycle, and its results appear after the next rising edge. `done` pulses together with the last result beat, and `ready` is high again in that cycle.
- R10: Compares (codes 4 to 6) and the unused codes 3 and 7 never raise a result write. Codes 3 and 7 also leave the flag register unchanged.
- R11: After reset, `ready` is 1, `grp_req`, `done` and `res_we` are 0, and every flag is 0.
- R12: A `start` pulse while `ready` is 0 is ignored, and the running operation finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while ready) |
| op | input | 3 | Operation code |
| scalar_form | input | 1 | 1: scalar replaces the first operand |
| masked | input | 1 | 1: arithmetic writes only flagged elements |
| vl | input | VLW (7) | Number of elements to process |
| scalar | input | W (16) | Scalar operand |
| a_grp | input | LANES*W (64) | First operands of the requested group |
| b_grp | input | LANES*W (64) | Second operands of the requested group |
| ready | output | 1 | Unit idle, start may be given |
| grp_req | output | 1 | Operands for grp_idx are sampled this cycle |
| grp_idx | output | GW (4) | Group being requested |
| res_we | output | LANES (4) | Per-lane result write strobe |
| res_data | output | LANES*W (64) | Per-lane results |
| res_grp | output | GW (4) | Group of the current result beat |
| done | output | 1 | Last result beat of an operation |
| flags | output | MVL (64) | Flag register, one bit per element |

## Verification
The bench targets the partial last group (vl of 13 and 37). A wrong lane enable there would write elements past the length. It also runs vl=0, where a sequencer that always issues one group would raise `grp_req` or write a beat, and vl=100, which must be clamped rather than wrapped into a short run. A short equality compare after a full not-equal compare checks that flags past the length survive. Masked and unmasked runs over a mixed flag pattern catch a mask that is ignored or applied when it should not be. A `start` pulse in the middle of a run catches a design that restarts or takes the new code.

// File: rtl/vec_alu_pkg.sv
// Shared definitions for the vector ALU: operation codes and their classes.
package vec_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_NOP3 = 3'd3,
        OP_CNE  = 3'd4,
        OP_CEQ  = 3'd5,
        OP_CLTU = 3'd6,
        OP_NOP7 = 3'd7
    } vop_e;

    // True for operations that produce element results.
    function automatic logic op_is_arith(input vop_e o);
        return (o == OP_ADD) || (o == OP_SUB) || (o == OP_MUL);
    endfunction

    // True for operations that write the flag register.
    function automatic logic op_is_cmp(input vop_e o);
        return (o == OP_CNE) || (o == OP_CEQ) || (o == OP_CLTU);
    endfunction

endpackage

// File: rtl/vec_issue_ctrl.sv
// Issue sequencer. It accepts an operation when idle, walks the element
// groups one per cycle, and carries the per-group control (valid, group,
// last) down the two-stage pipeline.
// Assumes: LANES is a power of two and at least 2; MVL is a multiple of LANES.
module vec_issue_ctrl #(
    parameter int LANES = 4,
    parameter int MVL   = 64,
    localparam int VLW  = $clog2(MVL) + 1,
    localparam int GW   = $clog2(MVL / LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    output logic             cmd_load,
    output logic             ready,
    output logic             grp_req,
    output logic [GW-1:0]    grp_idx,
    output logic [LANES-1:0] lane_en,
    output logic [GW-1:0]    s1_grp,
    output logic [GW-1:0]    out_grp,
    output logic             done
);
    localparam int LW = $clog2(LANES);

    logic             busy;
    logic [GW-1:0]    grp;
    logic [VLW-1:0]   vl_q;
    logic [VLW-1:0]   vl_eff;
    logic [VLW-1:0]   grp_base;
    logic [VLW-1:0]   next_base;
    logic             last_grp;
    logic             s1_act;
    logic             s1_last;
    logic [GW-1:0]    s1_grp_q;

    // Lengths above the maximum are clamped to it.
    assign vl_eff    = (vl_in > VLW'(MVL)) ? VLW'(MVL) : vl_in;
    // Idle only when nothing is issuing or in flight.
    assign ready     = !busy && !s1_act && !s1_last;
    assign cmd_load  = start && ready;
    assign grp_base  = VLW'(grp) << LW;
    assign next_base = grp_base + VLW'(LANES);
    assign last_grp  = next_base >= vl_q;
    assign grp_req   = busy;
    assign grp_idx   = grp;
    assign s1_grp    = s1_grp_q;

    // Per-lane enable: element index below the latched length.
    for (genvar l = 0; l < LANES; l++) begin : g_en
        assign lane_en[l] = busy && ((grp_base + VLW'(l)) < vl_q);
    end

    // Group walk: load on accept, step each cycle, stop after the last group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            grp  <= '0;
            vl_q <= '0;
        end else if (cmd_load) begin
            busy <= (vl_eff != '0);
            grp  <= '0;
            vl_q <= vl_eff;
        end else if (busy) begin
            if (last_grp) begin
                busy <= 1'b0;
            end else begin
                grp <= grp + 1'b1;
            end
        end
    end

    // Stage-1 control: follows the operands into the lane compute stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_act   <= 1'b0;
            s1_last  <= 1'b0;
            s1_grp_q <= '0;
        end else begin
            s1_act   <= busy;
            s1_last  <= (busy && last_grp) || (cmd_load && (vl_eff == '0));
            s1_grp_q <= grp;
        end
    end

    // Output-stage control: group tag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            out_grp <= '0;
        end else begin
            done    <= s1_last;
            out_grp <= s1_grp_q;
        end
    end

endmodule

// File: rtl/vec_lane.sv
// One execution lane. It registers one element's operands, computes the
// arithmetic or compare result, and registers the result with its write
// strobe. Compare outcomes leave combinationally for the flag file.
// Assumes: op, use_scalar, masked and scalar stay stable during an operation.
module vec_lane
    import vec_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         en,
    input  logic [W-1:0] a_el,
    input  logic [W-1:0] b_el,
    input  logic [W-1:0] scalar,
    input  logic         use_scalar,
    input  vop_e         op,
    input  logic         masked,
    input  logic         mask_bit,
    output logic         res_we,
    output logic [W-1:0] res_data,
    output logic         cmp_wr,
    output logic         cmp_bit
);
    logic         s1_en;
    logic [W-1:0] s1_x;
    logic [W-1:0] s1_y;
    logic [W-1:0] alu_r;
    logic         cmp_r;
    logic         wr;

    // Operand stage: pick scalar or vector first operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_en <= 1'b0;
            s1_x  <= '0;
            s1_y  <= '0;
        end else begin
            s1_en <= take && en;
            if (take) begin
                s1_x <= use_scalar ? scalar : a_el;
                s1_y <= b_el;
            end
        end
    end

    // Element function for the current code.
    always_comb begin
        alu_r = '0;
        cmp_r = 1'b0;
        case (op)
            OP_ADD:  alu_r = s1_x + s1_y;
            OP_SUB:  alu_r = s1_x - s1_y;
            OP_MUL:  alu_r = s1_x * s1_y;
            OP_CNE:  cmp_r = (s1_x != s1_y);
            OP_CEQ:  cmp_r = (s1_x == s1_y);
            OP_CLTU: cmp_r = (s1_x < s1_y);
            default: ;
        endcase
    end

    assign wr      = s1_en && op_is_arith(op) && (!masked || mask_bit);
    assign cmp_wr  = s1_en && op_is_cmp(op);
    assign cmp_bit = cmp_r;

    // Result stage: strobe every cycle, data held unless written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_we   <= 1'b0;
            res_data <= '0;
        end else begin
            res_we <= wr;
            if (wr) begin
                res_data <= alu_r;
            end
        end
    end

endmodule

// File: rtl/vec_flag_file.sv
// Flag register, one bit per element. It serves the mask bits of one group
// to the lanes and takes that group's compare bits back in the same cycle.
// Assumes: LANES is a power of two and at least 2; MVL is a multiple of LANES.
module vec_flag_file #(
    parameter int LANES = 4,
    parameter int MVL   = 64,
    localparam int GW   = $clog2(MVL / LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GW-1:0]    grp,
    input  logic [LANES-1:0] wr,
    input  logic [LANES-1:0] bit_in,
    output logic [LANES-1:0] rd,
    output logic [MVL-1:0]   flags
);
    localparam int LW = $clog2(LANES);

    // Mask read for the group in the compute stage.
    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd[l] = flags[{grp, LW'(l)}];
    end

    // Per-lane flag update; unwritten bits keep their value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr[l]) begin
                    flags[{grp, LW'(l)}] <= bit_in[l];
                end
            end
        end
    end

endmodule

// File: rtl/vec_alu.sv
// Masked multi-lane vector ALU top. It latches the command on accept, runs
// the issue sequencer, fans the operands out to LANES identical lanes and
// ties the lanes to the shared flag register.
// Assumes: the caller drives a_grp/b_grp for grp_idx whenever grp_req is high.
module vec_alu
    import vec_alu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int W     = 16,
    parameter int MVL   = 64,
    localparam int VLW  = $clog2(MVL) + 1,
    localparam int GW   = $clog2(MVL / LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op,
    input  logic               scalar_form,
    input  logic               masked,
    input  logic [VLW-1:0]     vl,
    input  logic [W-1:0]       scalar,
    input  logic [LANES*W-1:0] a_grp,
    input  logic [LANES*W-1:0] b_grp,
    output logic               ready,
    output logic               grp_req,
    output logic [GW-1:0]      grp_idx,
    output logic [LANES-1:0]   res_we,
    output logic [LANES*W-1:0] res_data,
    output logic [GW-1:0]      res_grp,
    output logic               done,
    output logic [MVL-1:0]     flags
);
    logic             cmd_load;
    logic [LANES-1:0] lane_en;
    logic [GW-1:0]    s1_grp;
    logic [LANES-1:0] mask_rd;
    logic [LANES-1:0] cmp_wr;
    logic [LANES-1:0] cmp_bit;
    vop_e             op_q;
    logic             form_q;
    logic             masked_q;
    logic [W-1:0]     scalar_q;

    // Command register: captured once per accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ADD;
            form_q   <= 1'b0;
            masked_q <= 1'b0;
            scalar_q <= '0;
        end else if (cmd_load) begin
            op_q     <= vop_e'(op);
            form_q   <= scalar_form;
            masked_q <= masked;
            scalar_q <= scalar;
        end
    end

    vec_issue_ctrl #(.LANES(LANES), .MVL(MVL)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .vl_in    (vl),
        .cmd_load (cmd_load),
        .ready    (ready),
        .grp_req  (grp_req),
        .grp_idx  (grp_idx),
        .lane_en  (lane_en),
        .s1_grp   (s1_grp),
        .out_grp  (res_grp),
        .done     (done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vec_lane #(.W(W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (grp_req),
            .en         (lane_en[l]),
            .a_el       (a_grp[l*W +: W]),
            .b_el       (b_grp[l*W +: W]),
            .scalar     (scalar_q),
            .use_scalar (form_q),
            .op         (op_q),
            .masked     (masked_q),
            .mask_bit   (mask_rd[l]),
            .res_we     (res_we[l]),
            .res_data   (res_data[l*W +: W]),
            .cmp_wr     (cmp_wr[l]),
            .cmp_bit    (cmp_bit[l])
        );
    end

    vec_flag_file #(.LANES(LANES), .MVL(MVL)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .grp    (s1_grp),
        .wr     (cmp_wr),
        .bit_in (cmp_bit),
        .rd     (mask_rd),
        .flags  (flags)
    );

endmodule

// File: rtl/vec_alu_chk.sv
// Protocol checker for vec_alu, attached with bind. It watches the ports
// plus the latched operation code and the lane compare strobes.
module vec_alu_chk #(
    parameter int LANES = 4,
    parameter int MVL   = 64,
    localparam int VLW  = $clog2(MVL) + 1,
    localparam int GW   = $clog2(MVL / LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ready,
    input logic [VLW-1:0]   vl,
    input logic             grp_req,
    input logic [GW-1:0]    grp_idx,
    input logic             done,
    input logic [MVL-1:0]   flags,
    input logic [2:0]       op_q,
    input logic [LANES-1:0] cmp_wr
);

    // R9: no new operation can be taken while groups are issuing.
    a_r9_issue_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grp_req |-> !ready);

    // R9: consecutive request cycles step the group number by one.
    a_r9_grp_step: assert property (@(posedge clk) disable iff (!rst_n)
        grp_req |=> (!grp_req || (grp_idx == $past(grp_idx) + 1'b1)));

    // R9: the completion pulse leaves the unit idle.
    a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && !grp_req));

    // R5: a zero-length operation issues nothing and completes two edges on.
    a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && (vl == '0)) |=> (!grp_req ##1 done));

    // R12: a start while busy leaves the latched operation alone.
    a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ready) |=> $stable(op_q));

    // R10: without a compare write the flag register holds.
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr == '0) |=> $stable(flags));

endmodule

bind vec_alu vec_alu_chk #(.LANES(LANES), .MVL(MVL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ready   (ready),
    .vl      (vl),
    .grp_req (grp_req),
    .grp_idx (grp_idx),
    .done    (done),
    .flags   (flags),
    .op_q    (op_q),
    .cmp_wr  (cmp_wr)
);

// File: tb/tb_vec_alu.sv
// Directed bench for vec_alu: one task per scenario, each checking its own
// results against a model built from the requirements.
module tb_vec_alu;
    localparam int LANES = 4;
    localparam int W     = 16;
    localparam int MVL   = 64;
    localparam int VLW   = 7;
    localparam int GW    = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start;
    logic [2:0]         op;
    logic               scalar_form;
    logic               masked;
    logic [VLW-1:0]     vl;
    logic [W-1:0]       scalar;
    logic [LANES*W-1:0] a_grp;
    logic [LANES*W-1:0] b_grp;
    logic               ready;
    logic               grp_req;
    logic [GW-1:0]      grp_idx;
    logic [LANES-1:0]   res_we;
    logic [LANES*W-1:0] res_data;
    logic [GW-1:0]      res_grp;
    logic               done;
    logic [MVL-1:0]     flags;

    always #10 clk = ~clk;

    vec_alu #(.LANES(LANES), .W(W), .MVL(MVL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .scalar_form(scalar_form), .masked(masked), .vl(vl), .scalar(scalar),
        .a_grp(a_grp), .b_grp(b_grp), .ready(ready), .grp_req(grp_req),
        .grp_idx(grp_idx), .res_we(res_we), .res_data(res_data),
        .res_grp(res_grp), .done(done), .flags(flags)
    );

    int checks = 0;
    int errors = 0;

    logic [W-1:0]   A [MVL];
    logic [W-1:0]   B [MVL];
    logic [MVL-1:0] mflags;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_arith(input logic [2:0] c,
                                                 input logic [W-1:0] x,
                                                 input logic [W-1:0] y);
        logic [W-1:0] r;
        case (c)
            3'd0:    r = x + y;
            3'd1:    r = x - y;
            default: r = x * y;
        endcase
        return r;
    endfunction

    function automatic logic model_cmp(input logic [2:0] c,
                                       input logic [W-1:0] x,
                                       input logic [W-1:0] y);
        case (c)
            3'd4:    return x != y;
            3'd5:    return x == y;
            default: return x < y;
        endcase
    endfunction

    // Operand fill: mode 0 random, mode 1 equal on every third element.
    task automatic fill(input int mode);
        for (int i = 0; i < MVL; i++) begin
            A[i] = W'($urandom);
            if (mode == 0) B[i] = W'($urandom);
            else           B[i] = (i % 3 == 0) ? A[i] : A[i] + W'(i + 1);
        end
    endtask

    // Run one operation, model it, and check writes, flags and timing.
    task automatic run_op(input logic [2:0] opc, input bit sv, input bit msk,
                          input int vl_req, input logic [W-1:0] s,
                          input string req, input bit poke);
        int vle, ngrp, cyc, issues, done_cyc, bad, idx;
        bit seq_bad, dbl, rdy_done;
        logic [W-1:0] bad_act, bad_exp, x;
        logic [MVL-1:0] exp_flags;
        bit exp_we [MVL];
        bit got_we [MVL];
        logic [W-1:0] exp_d [MVL];
        logic [W-1:0] got_d [MVL];
        string ttag;

        vle  = (vl_req > MVL) ? MVL : vl_req;
        ngrp = (vle + LANES - 1) / LANES;
        exp_flags = mflags;
        for (int i = 0; i < MVL; i++) begin
            exp_we[i] = 1'b0;
            exp_d[i]  = '0;
            got_we[i] = 1'b0;
            got_d[i]  = '0;
            if (i < vle) begin
                x = sv ? s : A[i];
                if (opc <= 3'd2) begin
                    exp_we[i] = !msk || mflags[i];
                    exp_d[i]  = model_arith(opc, x, B[i]);
                end else if (opc >= 3'd4 && opc <= 3'd6) begin
                    exp_flags[i] = model_cmp(opc, x, B[i]);
                end
            end
        end

        @(negedge clk);
        start = 1'b1; op = opc; scalar_form = sv; masked = msk;
        vl = VLW'(vl_req); scalar = s;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; issues = 0; done_cyc = 0; seq_bad = 0; dbl = 0; rdy_done = 0;
        while (done_cyc == 0 && cyc < 300) begin
            cyc++;
            if (poke && cyc == 2) begin
                start = 1'b1; op = 3'd2; vl = 7'd4;
            end else if (poke && cyc == 3) begin
                start = 1'b0; op = opc; vl = VLW'(vl_req);
            end
            if (grp_req) begin
                if (int'(grp_idx) != issues) seq_bad = 1;
                for (int l = 0; l < LANES; l++) begin
                    a_grp[l*W +: W] = A[int'(grp_idx)*LANES + l];
                    b_grp[l*W +: W] = B[int'(grp_idx)*LANES + l];
                end
                issues++;
            end
            for (int l = 0; l < LANES; l++) begin
                if (res_we[l]) begin
                    idx = int'(res_grp) * LANES + l;
                    if (got_we[idx]) dbl = 1;
                    got_we[idx] = 1'b1;
                    got_d[idx]  = res_data[l*W +: W];
                end
            end
            if (done) begin
                done_cyc = cyc;
                rdy_done = ready;
            end
            if (done_cyc == 0) @(negedge clk);
        end

        ttag = (vle == 0) ? "R5" : "R9";
        chk(issues == ngrp && !seq_bad, ttag, "issue cycles", 64'(issues), 64'(ngrp));
        chk(done_cyc == ngrp + 2, ttag, "done cycle", 64'(done_cyc), 64'(ngrp + 2));
        chk(rdy_done, "R9", "ready at done", 64'(rdy_done), 64'd1);

        bad = 0; bad_act = '0; bad_exp = '0;
        for (int i = 0; i < MVL; i++) begin
            if (got_we[i] != exp_we[i] || (exp_we[i] && got_d[i] != exp_d[i])) begin
                if (bad == 0) begin
                    bad_act = got_we[i] ? got_d[i] : 'x;
                    bad_exp = exp_we[i] ? exp_d[i] : 'x;
                    $display("  element %0d: we %0d/%0d", i, got_we[i], exp_we[i]);
                end
                bad++;
            end
        end
        chk(bad == 0 && !dbl, req, "element writes", 64'(bad_act), 64'(bad_exp));
        chk(flags == exp_flags, req, "flag register", flags, exp_flags);
        mflags = exp_flags;
    endtask

    task automatic t_reset;
        chk(ready == 1'b1, "R11", "ready after reset", 64'(ready), 64'd1);
        chk(!grp_req && !done, "R11", "idle strobes", {62'd0, grp_req, done}, 64'd0);
        chk(res_we == '0, "R11", "no writes", 64'(res_we), 64'd0);
        chk(flags == '0, "R11", "flags cleared", flags, 64'd0);
    endtask

    task automatic t_vector_forms;
        fill(0);
        run_op(3'd0, 1'b0, 1'b0, 64, '0, "R1", 1'b0);
        run_op(3'd2, 1'b0, 1'b0, 64, '0, "R3", 1'b0);
        run_op(3'd1, 1'b0, 1'b0, 13, '0, "R4", 1'b0);
        run_op(3'd2, 1'b0, 1'b0, 37, '0, "R1", 1'b0);
        run_op(3'd0, 1'b0, 1'b0, 100, '0, "R4", 1'b0);
    endtask

    task automatic t_scalar_forms;
        fill(0);
        run_op(3'd0, 1'b1, 1'b0, 20, 16'h1234, "R2", 1'b0);
        run_op(3'd2, 1'b1, 1'b0, 64, 16'd3, "R2", 1'b0);
        run_op(3'd1, 1'b1, 1'b0, 7, 16'h0005, "R2", 1'b0);
    endtask

    task automatic t_zero_length;
        fill(1);
        run_op(3'd0, 1'b0, 1'b0, 0, '0, "R5", 1'b0);
        run_op(3'd4, 1'b0, 1'b0, 0, '0, "R5", 1'b0);
    endtask

    task automatic t_compares;
        fill(1);
        run_op(3'd4, 1'b0, 1'b0, 64, '0, "R6", 1'b0);
        run_op(3'd5, 1'b0, 1'b0, 10, '0, "R6", 1'b0);
        fill(0);
        run_op(3'd6, 1'b0, 1'b0, 30, '0, "R6", 1'b0);
        run_op(3'd4, 1'b1, 1'b1, 64, 16'h00ff, "R10", 1'b0);
    endtask

    task automatic t_masked;
        fill(1);
        run_op(3'd4, 1'b0, 1'b0, 64, '0, "R6", 1'b0);
        run_op(3'd1, 1'b0, 1'b1, 64, '0, "R7", 1'b0);
        run_op(3'd0, 1'b1, 1'b1, 22, 16'h0101, "R7", 1'b0);
    endtask

    task automatic t_unmasked;
        fill(0);
        run_op(3'd0, 1'b0, 1'b0, 64, '0, "R8", 1'b0);
    endtask

    task automatic t_reserved;
        fill(0);
        run_op(3'd3, 1'b0, 1'b0, 64, '0, "R10", 1'b0);
        run_op(3'd7, 1'b0, 1'b1, 64, '0, "R10", 1'b0);
    endtask

    task automatic t_busy_start;
        fill(0);
        run_op(3'd0, 1'b0, 1'b0, 64, '0, "R12", 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=%0h expected=%0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op = '0; scalar_form = 1'b0; masked = 1'b0;
        vl = '0; scalar = '0; a_grp = '0; b_grp = '0; mflags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vector_forms();
        t_scalar_forms();
        t_zero_length();
        t_compares();
        t_masked();
        t_unmasked();
        t_reserved();
        t_busy_start();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule